// File: doc/BRIEF.md
# Keyed Software Reset Line Controller

This block holds a bank of reset outputs that software drives for other on-chip blocks. A system-reset register keeps one assert bit per line. Software changes lines with a read-modify-write of that register: it reads the current bits, sets or clears the bit it wants, and writes the word back. A write takes effect only when the top byte of the write data carries the unlock key. The key guards against stray stores.

When the gating variant is built, a second register holds a software-control enable bit per line. Each output is the AND of its assert bit and its enable bit. The expected sequence is to set the enable, then assert, and later to deassert and then clear the enable. When the gating variant is not built, the assert bits drive the outputs directly. In that case the enable register reads as zero.

Both registers read back over a simple register port. The key byte always reads as zero. The outputs are registered, and each one follows its register bits one clock later.

Top module: `rst_line_ctrl`

## Requirements
- R1: After the asynchronous reset, every reset line is low, and both registers read as zero.
- R2: A write to offset 0x18 with data bits [31:24] equal to 0x88 loads data bits [23:0] into the assert register, where bit n belongs to line n.
- R3: A write to offset 0x18 with any other value in bits [31:24] leaves every assert bit unchanged.
- R4: A read of offset 0x18 returns the assert bits in [23:0] and zero in [31:24].
- R5: In the gating variant, a write to offset 0xFC loads data bits [23:0] into the enable register without needing a key. A read of 0xFC returns those bits in [23:0] and zero in [31:24].
- R6: In the gating variant, line n is high exactly when assert bit n and enable bit n were both set in the previous cycle.
- R7: In the variant without gating, line n equals assert bit n of the previous cycle, and offset 0xFC reads as zero and ignores writes.
- R8: Data bits at positions 24 and above never reach any register: they read back as zero.
- R9: Writes to any offset other than 0x18 and 0xFC change nothing, and reads of those offsets return zero.
- R10: A read (write strobe low) never changes any register or line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data; the key is in [31:24] for the assert register |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| rst_lines_o | output | 24 | Registered reset outputs, active high |

## Verification
A register write can land in the same cycle that the output register picks up the result of the previous write. So back-to-back writes to the enable and assert registers move the lines while a new write is being taken. The bench provokes this with directed pairs of writes and with long runs of random writes, reads, bad keys and unmapped offsets. It then compares both the gated and the ungated build with a behavioural model on every cycle. Because the lines lag the registers by one cycle, a lost or early update shows up as a mismatch on the very next cycle.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ASSERT = 2'd1,
    SEL_ENABLE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rst_ctl_decode.sv
module rst_ctl_decode
  import rst_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  KEY_VAL    = 8'h88,
  parameter logic [ADDR_W-1:0] ASSERT_OFF = 8'h18,
  parameter logic [ADDR_W-1:0] ENABLE_OFF = 8'hFC
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        key_i,
  output reg_sel_e          sel_o,
  output logic              wr_assert_o,
  output logic              wr_enable_o
);
  always_comb begin
    if (addr_i == ASSERT_OFF)      sel_o = SEL_ASSERT;
    else if (addr_i == ENABLE_OFF) sel_o = SEL_ENABLE;
    else                           sel_o = SEL_NONE;
  end

  // only the assert register is key-protected
  assign wr_assert_o = valid_i && write_i && (sel_o == SEL_ASSERT) && (key_i == KEY_VAL);
  assign wr_enable_o = valid_i && write_i && (sel_o == SEL_ENABLE);
endmodule

// File: rtl/rst_ctl_bitreg.sv
module rst_ctl_bitreg #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/rst_ctl_gate.sv
module rst_ctl_gate #(
  parameter int unsigned W     = 24,
  parameter bit          GATED = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] asrt_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] lines_o
);
  logic [W-1:0] nxt;

  generate
    if (GATED) begin : g_gated
      assign nxt = asrt_i & en_i;

      a_r6_no_line_without_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((lines_o & ~$past(en_i)) == '0));
    end else begin : g_direct
      assign nxt = asrt_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lines_o <= '0;
    else         lines_o <= nxt;
  end

  a_r6_lines_follow_assert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lines_o & ~$past(asrt_i)) == '0));
endmodule

// File: rtl/rst_line_ctrl.sv
module rst_line_ctrl
  import rst_ctl_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 24,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter logic [7:0]  KEY_VAL    = 8'h88,
  parameter logic [ADDR_W-1:0] ASSERT_OFF = 8'h18,
  parameter logic [ADDR_W-1:0] ENABLE_OFF = 8'hFC,
  parameter bit          GATE_LINES = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic [NUM_LINES-1:0] rst_lines_o
);
  localparam int unsigned KEY_LSB = DATA_W - 8;

  reg_sel_e             sel;
  logic                 wr_assert, wr_enable;
  logic [NUM_LINES-1:0] asrt_q, en_q;

  rst_ctl_decode #(
    .ADDR_W(ADDR_W), .KEY_VAL(KEY_VAL),
    .ASSERT_OFF(ASSERT_OFF), .ENABLE_OFF(ENABLE_OFF)
  ) u_decode (
    .valid_i(bus_valid_i), .write_i(bus_write_i), .addr_i(bus_addr_i),
    .key_i(bus_wdata_i[DATA_W-1:KEY_LSB]),
    .sel_o(sel), .wr_assert_o(wr_assert), .wr_enable_o(wr_enable)
  );

  rst_ctl_bitreg #(.W(NUM_LINES)) u_assert_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_assert),
    .d_i(bus_wdata_i[NUM_LINES-1:0]), .q_o(asrt_q)
  );

  generate
    if (GATE_LINES) begin : g_enable
      rst_ctl_bitreg #(.W(NUM_LINES)) u_enable_reg (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_enable),
        .d_i(bus_wdata_i[NUM_LINES-1:0]), .q_o(en_q)
      );

      a_r5_enable_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && bus_write_i && bus_addr_i == ENABLE_OFF)
        |=> (en_q == $past(bus_wdata_i[NUM_LINES-1:0])));
    end else begin : g_no_enable
      assign en_q = '0;
    end
  endgenerate

  rst_ctl_gate #(.W(NUM_LINES), .GATED(GATE_LINES)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .asrt_i(asrt_q), .en_i(en_q), .lines_o(rst_lines_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (sel)
      SEL_ASSERT: bus_rdata_o[NUM_LINES-1:0] = asrt_q;
      SEL_ENABLE: bus_rdata_o[NUM_LINES-1:0] = en_q;
      default:    bus_rdata_o = '0;
    endcase
  end

  a_r2_keyed_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i == ASSERT_OFF &&
     bus_wdata_i[DATA_W-1:KEY_LSB] == KEY_VAL)
    |=> (asrt_q == $past(bus_wdata_i[NUM_LINES-1:0])));

  a_r3_bad_key_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i == ASSERT_OFF &&
     bus_wdata_i[DATA_W-1:KEY_LSB] != KEY_VAL)
    |=> $stable(asrt_q));

  a_r9_unmapped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i != ASSERT_OFF && bus_addr_i != ENABLE_OFF)
    |=> ($stable(asrt_q) && $stable(en_q)));

  a_r10_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_write_i) |=> ($stable(asrt_q) && $stable(en_q)));
endmodule

// File: tb/rst_line_ctrl_tb.sv
module rst_line_ctrl_tb;
  localparam int PERIOD = 10;
  localparam logic [7:0] A_ASRT = 8'h18;
  localparam logic [7:0] A_EN   = 8'hFC;
  localparam logic [31:0] MASK  = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_g, rdata_u;
  logic [23:0] lines_g, lines_u;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference
  logic [31:0] m_asrt, m_en, m_lg, m_lu;

  always #(PERIOD/2) clk = ~clk;

  rst_line_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_g), .rst_lines_o(lines_g)
  );

  rst_line_ctrl #(.GATE_LINES(1'b0)) u_dut_ng (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_u), .rst_lines_o(lines_u)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_asrt <= 0; m_en <= 0; m_lg <= 0; m_lu <= 0;
    end else begin
      m_lg <= m_asrt & m_en;
      m_lu <= m_asrt;
      if (valid && write) begin
        if (addr == A_ASRT && wdata[31:24] == 8'h88) m_asrt <= wdata & MASK;
        if (addr == A_EN) m_en <= wdata & MASK;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input bit gated);
    if (a == A_ASRT) return m_asrt;
    if (a == A_EN)   return gated ? m_en : 32'h0;
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_ni && !done) begin
      check("R6 gated lines", {8'h0, lines_g}, m_lg);
      check("R7 direct lines", {8'h0, lines_u}, m_lu);
      check(addr == A_ASRT ? "R4 rdata" : (addr == A_EN ? "R5 rdata" : "R9 rdata"),
            rdata_g, exp_rd(addr, 1'b1));
      check(addr == A_EN ? "R7 rdata" : "R4 rdata ng", rdata_u, exp_rd(addr, 1'b0));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp_g,
                    input logic [31:0] exp_u, input string tag);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a; wdata = 32'hFFFF_FFFF;
    #(PERIOD/4);
    check(tag, rdata_g, exp_g);
    check(tag, rdata_u, exp_u);
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1 lines", {8'h0, lines_g}, 32'h0);
    rd(A_ASRT, 32'h0, 32'h0, "R1");
    rd(A_EN, 32'h0, 32'h0, "R1");

    // R5, R8: enable without key, upper bits dropped
    wr(A_EN, 32'hFFFF_FF0F);
    rd(A_EN, 32'h00FF_FF0F, 32'h0, "R5 R8 R7");
    // R2: keyed assert
    wr(A_ASRT, 32'h88A5_A5A5);
    rd(A_ASRT, 32'h00A5_A5A5, 32'h00A5_A5A5, "R2");
    check("R6 lines", {8'h0, lines_g}, 32'h00A5_A505);
    check("R7 lines", {8'h0, lines_u}, 32'h00A5_A5A5);
    // R3: wrong keys
    wr(A_ASRT, 32'h7700_0000);
    wr(A_ASRT, 32'h8900_0000);
    wr(A_ASRT, 32'h0800_0000);
    rd(A_ASRT, 32'h00A5_A5A5, 32'h00A5_A5A5, "R3");
    // R9: unmapped offsets
    wr(8'h40, 32'h8800_0000);
    wr(8'h1C, 32'h8800_0000);
    rd(8'h40, 32'h0, 32'h0, "R9");
    rd(A_ASRT, 32'h00A5_A5A5, 32'h00A5_A5A5, "R9");
    // R10: read with a keyed data pattern changes nothing
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = A_ASRT; wdata = 32'h8800_0000;
    @(negedge clk);
    valid = 1'b0;
    rd(A_ASRT, 32'h00A5_A5A5, 32'h00A5_A5A5, "R10");
    // enable-then-assert back to back, then deassert-then-disable
    wr(A_EN, 32'h0000_0001);
    wr(A_ASRT, 32'h8800_0001);
    @(negedge clk);
    check("R6 ordered", {8'h0, lines_g}, 32'h1);
    wr(A_ASRT, 32'h8800_0000);
    wr(A_EN, 32'h0);
    @(negedge clk);
    check("R6 released", {8'h0, lines_g}, 32'h0);

    // random traffic checked per cycle
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      valid = 1'($urandom_range(0, 3) != 0);
      write = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 5))
        0, 1:    addr = A_ASRT;
        2, 3:    addr = A_EN;
        4:       addr = 8'h1C;
        default: addr = 8'($urandom);
      endcase
      wdata = $urandom;
      if ($urandom_range(0, 1) == 1) wdata[31:24] = 8'h88;
    end
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule